// File: doc/BRIEF.md
# Store-Queue Forwarding Candidate Mask Generator

When a load runs, this block works out which store-queue entries could hold data that the load must receive by store-to-load forwarding. The store queue is a circular buffer. Each pointer into it is an entry index plus a wrap bit, and the wrap bit toggles each time the pointer passes the last entry. The block takes the dequeue pointer (the oldest store), the load's store-queue pointer (the first store younger than the load), the load address, and for every entry the stored address, a whole-line flag and an address-valid bit.

The block produces two entry masks. The older mask covers candidates that lie before the wrap point. The younger mask covers candidates that lie after the wrap point, so every entry in it is younger than any entry in the older mask. Inside each mask, a higher index is a younger store. A downstream data selector must therefore give the younger mask priority, and then give higher indices priority. An entry is a candidate only if it lies in the age range, its address matches the load, and its address is valid.

The outputs are computed combinationally. When `OUT_REG` is 1 (the default), they pass through one register stage. The register resets to all zeros.

Top module: `sq_fwd_mask_gen`

## Requirements
- R1: When the two wrap bits are equal, older-mask bit j is set exactly for deq_idx <= j < ld_idx, provided the address matches and the entry's address is valid.
- R2: When the two wrap bits are equal, the younger mask is all zeros.
- R3: When the wrap bits differ, older-mask bit j is set exactly for deq_idx <= j <= DEPTH-1, under the same match and valid gating.
- R4: When the wrap bits differ, younger-mask bit j is set exactly for 0 <= j < ld_idx, under the same gating. Its bits never overlap the older mask for a legal pointer pair.
- R5: When the load pointer equals the dequeue pointer (same index and same wrap bit), both masks are all zeros.
- R6: An entry with its line flag clear matches only when address bits [AW-1:LINE_OFS] and bits [LINE_OFS-1:WORD_OFS] both equal those of the load. Bits below WORD_OFS are ignored.
- R7: An entry with its line flag set matches whenever bits [AW-1:LINE_OFS] are equal, whatever its word-offset bits hold.
- R8: An entry whose address-valid bit is 0 never appears in either mask.
- R9: With OUT_REG=1, both masks are all zeros while rst_n is low. Afterwards they show the inputs that were present at the previous rising clock edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| deq_idx | input | $clog2(DEPTH) | Index of the oldest store entry |
| deq_wrap | input | 1 | Wrap bit of the dequeue pointer |
| ld_idx | input | $clog2(DEPTH) | Index of the load's store-queue pointer |
| ld_wrap | input | 1 | Wrap bit of the load's store-queue pointer |
| ld_addr | input | AW | Load address |
| ent_addr | input | DEPTH*AW | Stored addresses; entry j occupies bits [j*AW +: AW] |
| ent_line | input | DEPTH | Per-entry flag: the stored address covers a whole line |
| ent_valid | input | DEPTH | Per-entry address-valid bits |
| mask_old | output | DEPTH | Candidates before the wrap point |
| mask_young | output | DEPTH | Candidates after the wrap point |

## Verification
The hardest case to reach is a wrapped queue that is exactly full. Here the two indices are equal but the wrap bits differ, so the whole queue splits at the dequeue index. This case must not be confused with the empty case, where the wrap bits are also equal. The stimulus table names both cases explicitly, together with wraps that end at entry 0 and at the last entry. The random phase draws a legal occupancy from 0 to DEPTH on top of a random dequeue pointer. It also mixes entries in the same line and same word, in the same line with a different word, and in a different line, and it toggles the line flag and the valid bit. Each result is compared with a reference that steps the pointer forward in age order.

// File: rtl/sq_fwd_mask_gen.sv
module sq_fwd_mask_gen #(
  parameter int DEPTH    = 16,
  parameter int AW       = 40,
  parameter int LINE_OFS = 6,
  parameter int WORD_OFS = 3,
  parameter bit OUT_REG  = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(DEPTH)-1:0] deq_idx,
  input  logic                  deq_wrap,
  input  logic [$clog2(DEPTH)-1:0] ld_idx,
  input  logic                  ld_wrap,
  input  logic [AW-1:0]         ld_addr,
  input  logic [DEPTH*AW-1:0]   ent_addr,
  input  logic [DEPTH-1:0]      ent_line,
  input  logic [DEPTH-1:0]      ent_valid,
  output logic [DEPTH-1:0]      mask_old,
  output logic [DEPTH-1:0]      mask_young
);
  localparam int IW = $clog2(DEPTH);

  logic             same_wrap;
  logic [DEPTH-1:0] at_or_after_deq, before_ld, addr_hit;
  logic [DEPTH-1:0] old_c, young_c;
  logic             unused_low;

  assign same_wrap  = (deq_wrap == ld_wrap);
  assign unused_low = ^ld_addr[WORD_OFS-1:0];

  for (genvar j = 0; j < DEPTH; j++) begin : g_ent
    logic [AW-1:0] a;
    logic          tag_eq, word_eq;
    logic          unused_ent_low;
    assign a               = ent_addr[j*AW +: AW];
    assign unused_ent_low  = ^a[WORD_OFS-1:0];
    assign tag_eq          = (a[AW-1:LINE_OFS] == ld_addr[AW-1:LINE_OFS]);
    assign word_eq         = (a[LINE_OFS-1:WORD_OFS] == ld_addr[LINE_OFS-1:WORD_OFS]);
    assign addr_hit[j]     = ent_valid[j] & tag_eq & (word_eq | ent_line[j]);
    assign at_or_after_deq[j] = (IW'(j) >= deq_idx);
    assign before_ld[j]       = (IW'(j) < ld_idx);
  end

  assign old_c   = addr_hit & (same_wrap ? (at_or_after_deq & before_ld) : at_or_after_deq);
  assign young_c = same_wrap ? '0 : (addr_hit & before_ld);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_old   <= '0;
        mask_young <= '0;
      end else begin
        mask_old   <= old_c;
        mask_young <= young_c;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign mask_old   = old_c;
    assign mask_young = young_c;
  end
endmodule

// File: rtl/sq_fwd_mask_gen_chk.sv
module sq_fwd_mask_gen_chk #(
  parameter int DEPTH   = 16,
  parameter bit OUT_REG = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [$clog2(DEPTH)-1:0] deq_idx,
  input logic                     deq_wrap,
  input logic [$clog2(DEPTH)-1:0] ld_idx,
  input logic                     ld_wrap,
  input logic [DEPTH-1:0]         ent_valid,
  input logic [DEPTH-1:0]         mask_old,
  input logic [DEPTH-1:0]         mask_young
);
  logic [DEPTH-1:0] below_deq;
  logic             legal;
  assign below_deq = (DEPTH'(1) << deq_idx) - DEPTH'(1);
  assign legal     = (deq_wrap == ld_wrap) ? (ld_idx >= deq_idx) : (ld_idx <= deq_idx);

  if (OUT_REG) begin : g_seq
    AST_SAME_WRAP_NO_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_wrap == ld_wrap) |=> (mask_young == '0)); // R2
    AST_EMPTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_wrap == ld_wrap && deq_idx == ld_idx) |=> (mask_old == '0 && mask_young == '0)); // R5
    AST_INVALID_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((mask_old | mask_young) & ~$past(ent_valid)) == '0)); // R8
    AST_OLD_NOT_BELOW_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((mask_old & $past(below_deq)) == '0)); // R3
    AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      legal |=> ((mask_old & mask_young) == '0)); // R4
  end else begin : g_cmb
    AST_SAME_WRAP_NO_YOUNG: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_wrap == ld_wrap) |-> (mask_young == '0)); // R2
    AST_EMPTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_wrap == ld_wrap && deq_idx == ld_idx) |-> (mask_old == '0 && mask_young == '0)); // R5
    AST_INVALID_EXCLUDED: assert property (@(posedge clk) disable iff (!rst_n)
      (((mask_old | mask_young) & ~ent_valid) == '0)); // R8
    AST_OLD_NOT_BELOW_DEQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_old & below_deq) == '0)); // R3
    AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
      legal |-> ((mask_old & mask_young) == '0)); // R4
  end
endmodule

bind sq_fwd_mask_gen sq_fwd_mask_gen_chk #(.DEPTH(DEPTH), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .deq_idx(deq_idx), .deq_wrap(deq_wrap),
  .ld_idx(ld_idx), .ld_wrap(ld_wrap), .ent_valid(ent_valid),
  .mask_old(mask_old), .mask_young(mask_young)
);

// File: tb/tb_sq_fwd_mask_gen.sv
module tb_sq_fwd_mask_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 40;
  localparam int LO = 6;
  localparam int WO = 3;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] deq_idx = '0, ld_idx = '0;
  logic deq_wrap = 1'b0, ld_wrap = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DEPTH*AW-1:0] ent_addr = '0;
  logic [DEPTH-1:0] ent_line = '0, ent_valid = '0;
  logic [DEPTH-1:0] mask_old, mask_young;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sq_fwd_mask_gen #(.DEPTH(DEPTH), .AW(AW), .LINE_OFS(LO), .WORD_OFS(WO), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .deq_idx(deq_idx), .deq_wrap(deq_wrap),
    .ld_idx(ld_idx), .ld_wrap(ld_wrap), .ld_addr(ld_addr), .ent_addr(ent_addr),
    .ent_line(ent_line), .ent_valid(ent_valid), .mask_old(mask_old), .mask_young(mask_young)
  );

  // {deq_wrap, deq_idx, ld_wrap, ld_idx, exp_old, exp_young}
  localparam int VW = 2 + 2*IW + 2*DEPTH;
  localparam logic [VW-1:0] VEC [8] = '{
    {1'b0, 4'd0,  1'b0, 4'd0,  16'h0000, 16'h0000},  // R5 empty
    {1'b0, 4'd2,  1'b0, 4'd5,  16'h001C, 16'h0000},  // R1 R2
    {1'b1, 4'd12, 1'b0, 4'd3,  16'hF000, 16'h0007},  // R3 R4
    {1'b0, 4'd15, 1'b1, 4'd0,  16'h8000, 16'h0000},  // R3 wrap at last entry
    {1'b1, 4'd7,  1'b1, 4'd7,  16'h0000, 16'h0000},  // R5
    {1'b0, 4'd0,  1'b0, 4'd15, 16'h7FFF, 16'h0000},  // R1
    {1'b1, 4'd5,  1'b0, 4'd5,  16'hFFE0, 16'h001F},  // R3 R4 full
    {1'b0, 4'd3,  1'b1, 4'd3,  16'hFFF8, 16'h0007}   // R3 R4 full
  };

  task automatic check(input string req, input logic [DEPTH-1:0] eo, input logic [DEPTH-1:0] ey);
    checks++;
    if (mask_old !== eo || mask_young !== ey) begin
      errors++;
      $display("FAIL %s: old=%h young=%h expected old=%h young=%h", req, mask_old, mask_young, eo, ey);
    end
  endtask

  task automatic drive_and_wait(input logic dw, input logic [IW-1:0] di,
                                input logic lw, input logic [IW-1:0] li);
    deq_wrap = dw; deq_idx = di; ld_wrap = lw; ld_idx = li;
    @(negedge clk);
  endtask

  function automatic logic hit(input int j);
    logic [AW-1:0] a;
    a = ent_addr[j*AW +: AW];
    return ent_valid[j] && a[AW-1:LO] == ld_addr[AW-1:LO] &&
           (a[LO-1:WO] == ld_addr[LO-1:WO] || ent_line[j]);
  endfunction

  task automatic reference(output logic [DEPTH-1:0] eo, output logic [DEPTH-1:0] ey);
    int idx = int'(deq_idx);
    logic w = deq_wrap;
    eo = '0; ey = '0;
    for (int n = 0; n < DEPTH; n++) begin
      if (idx == int'(ld_idx) && w == ld_wrap) break;
      if (hit(idx)) begin
        if (w == deq_wrap) eo[idx] = 1'b1; else ey[idx] = 1'b1;
      end
      if (idx == DEPTH-1) begin idx = 0; w = ~w; end else idx++;
    end
  endtask

  task automatic all_match();
    ld_addr = {28'h1234567, 3'd2, 3'd5};
    for (int j = 0; j < DEPTH; j++) ent_addr[j*AW +: AW] = {28'h1234567, 3'd2, 3'(j)};
    ent_line = '0; ent_valid = '1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DEPTH-1:0] eo, ey;
    all_match();
    deq_wrap = 1'b1; deq_idx = 4'd4; ld_wrap = 1'b0; ld_idx = 4'd4;
    repeat (3) @(negedge clk);
    check("R9 reset", '0, '0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      drive_and_wait(e[VW-1], e[VW-2 -: IW], e[VW-2-IW], e[VW-3-IW -: IW]);
      check("R1 R2 R3 R4 R5 table", e[2*DEPTH-1:DEPTH], e[DEPTH-1:0]);
    end

    // R9 latency: new inputs do not show before the next rising edge
    drive_and_wait(1'b0, 4'd0, 1'b0, 4'd4);
    deq_idx = 4'd8; ld_idx = 4'd10;
    #1;
    check("R9 before edge", 16'h000F, 16'h0000);
    @(negedge clk);
    check("R9 after edge", 16'h0300, 16'h0000);

    // R6 word mismatch excludes; low byte bits ignored
    all_match();
    ent_addr[1*AW +: AW] = {28'h1234567, 3'd3, 3'd1};
    ent_addr[2*AW +: AW] = {28'h1234566, 3'd2, 3'd2};
    drive_and_wait(1'b0, 4'd0, 1'b0, 4'd4);
    check("R6 word and tag compare", 16'h0009, 16'h0000);

    // R7 line flag covers word mismatch, not tag mismatch
    ent_line = 16'h0006;
    drive_and_wait(1'b0, 4'd0, 1'b0, 4'd4);
    check("R7 line flag", 16'h000B, 16'h0000);

    // R8 invalid entries dropped from both masks
    all_match();
    ent_valid = 16'hFEFE;
    drive_and_wait(1'b1, 4'd8, 1'b0, 4'd8);
    check("R8 valid gating", 16'hFE00, 16'h00FE);

    // random legal pointers, age-order reference
    for (int it = 0; it < 400; it++) begin
      int cnt, li;
      logic [27:0] tag;
      tag = 28'($urandom);
      ld_addr = {tag, 3'($urandom), 3'($urandom)};
      for (int j = 0; j < DEPTH; j++) begin
        case ($urandom_range(0, 3))
          0: ent_addr[j*AW +: AW] = {tag, ld_addr[LO-1:WO], 3'($urandom)};
          1, 2: ent_addr[j*AW +: AW] = {tag, 3'($urandom), 3'($urandom)};
          default: ent_addr[j*AW +: AW] = {tag ^ 28'(1 << $urandom_range(0, 27)), ld_addr[LO-1:0]};
        endcase
      end
      ent_line  = DEPTH'($urandom);
      ent_valid = DEPTH'($urandom) | DEPTH'($urandom);
      deq_idx  = IW'($urandom);
      deq_wrap = 1'($urandom);
      cnt = (it < 34) ? (it % (DEPTH+1)) : $urandom_range(0, DEPTH);
      li = int'(deq_idx) + cnt;
      ld_idx  = IW'(li % DEPTH);
      ld_wrap = (li >= DEPTH) ? ~deq_wrap : deq_wrap;
      reference(eo, ey);
      @(negedge clk);
      check("R1 R2 R3 R4 R5 R6 R7 R8 random", eo, ey);
    end

    // R9 reset clears a non-zero result
    all_match();
    drive_and_wait(1'b0, 4'd0, 1'b0, 4'd3);
    rst_n = 1'b0;
    #1;
    check("R9 async reset", '0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule